// File: doc/BRIEF.md
# Tick-Driven Count/Compare Timer with Pending Cause Bits

This block is a processor-side interval timer. A running count register advances by one on every cycle where the tick enable is high. A compare register holds a target value. When a tick moves the count onto the target value, a timer-pending flag is latched. The flag stays set until software writes the compare register again. Separately, a level-sensitive request from an external interrupt controller is registered into its own pending bit. Either pending bit drives the combined interrupt request output.

Software reaches the block through a small register port. Address 0 holds the count and address 1 holds the compare value. Address 2 returns the cause word, which is read-only. Writes land on the next clock edge, and reads are combinational.

The timer-pending flag is kept by a two-state machine. The states are `PEND_IDLE` (no timer event outstanding) and `PEND_SET` (timer event outstanding). There are three transitions:
- HIT: `PEND_IDLE` to `PEND_SET`, when a tick reaches the compare value and no compare write occurs in that cycle.
- CLEAR: `PEND_SET` to `PEND_IDLE`, on any compare write.
- HOLD: each state stays where it is otherwise.

Top module: `cmp_tick_timer`

## Requirements
- R1: After reset the count reads 1, the compare register reads 0, the cause word reads 0 and `irq_out` is low.
- R2: On each clock edge with `tick_en` high and no count write, the count increases by one. It wraps from all ones to 0 with no other effect. With `tick_en` low, the count holds.
- R3: A write to address 0 loads the count on the next edge and overrides a tick in that cycle, leaving the compare register unchanged. A write to address 1 loads the compare register, and the count keeps running.
- R4: When a tick moves the count onto the compare value, cause bit 15 (value 0x00008000) reads 1 after that edge and `irq_out` is high.
- R5: Cause bit 15 stays set until a compare write. A compare write clears it, and it wins over a match in the same cycle.
- R6: A write that leaves the count equal to the compare value raises no match. The next match comes after exactly 2^CNT_W ticks.
- R7: `ext_irq` is sampled on each edge into cause bit 10 (value 0x00000400). The bit follows the line level one cycle late.
- R8: `irq_out` is high exactly when cause bit 10 or cause bit 15 is set.
- R9: Writes to addresses 2 and 3 change nothing. Address 3 reads 0. Reads zero-extend the count and compare values to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Enables one count increment at this edge |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 count, 1 compare) |
| wr_data | input | 32 | Write data, low CNT_W bits used |
| rd_addr | input | 2 | Read address (0 count, 1 compare, 2 cause) |
| rd_data | output | 32 | Combinational read data |
| ext_irq | input | 1 | Level request from the external interrupt controller |
| irq_out | output | 1 | Combined hardware interrupt request |

## Verification
The bench builds the block with CNT_W = 8, which brings a full count wrap within 256 ticks. With that width, the rule that equality at a write defers the match by a whole wrap can be checked cycle by cycle. It also makes it possible to sweep every count value as a starting point, with a compare distance of one to four ticks, and to check the exact match cycle each time.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;
    localparam int TMR_BIT  = 15;
    localparam int EXT_BIT  = 10;

    localparam logic [ADDR_W-1:0] A_COUNT   = 2'd0;
    localparam logic [ADDR_W-1:0] A_COMPARE = 2'd1;
    localparam logic [ADDR_W-1:0] A_CAUSE   = 2'd2;

    typedef enum logic {
        PEND_IDLE = 1'b0,
        PEND_SET  = 1'b1
    } pend_state_t;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 32,
    parameter logic [CNT_W-1:0] RST_VAL = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_inc
);
    assign count_inc = count_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= RST_VAL;
        else if (load)
            count_q <= load_val;
        else if (tick)
            count_q <= count_inc;
    end
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             count_load,
    input  logic [CNT_W-1:0] count_inc,
    output logic [CNT_W-1:0] compare_q,
    output logic             hit
);
    always_ff @(posedge clk) begin
        if (rst)
            compare_q <= '0;
        else if (load)
            compare_q <= load_val;
    end

    // A hit only comes from an increment landing on the target,
    // so a write that creates equality never produces one.
    assign hit = tick && !count_load && (count_inc == compare_q);
endmodule

// File: rtl/tmr_pend_fsm.sv
module tmr_pend_fsm
    import cmp_timer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic clear,
    output logic pending
);
    pend_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= PEND_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PEND_IDLE: if (hit && !clear) state_d = PEND_SET;
            PEND_SET:  if (clear)         state_d = PEND_IDLE;
            default:                      state_d = PEND_IDLE;
        endcase
    end

    always_comb begin
        pending = (state_q == PEND_SET);
    end
endmodule

// File: rtl/cmp_tick_timer.sv
module cmp_tick_timer
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ext_irq,
    output logic              irq_out
);
    logic             cnt_wr, cmp_wr, hit, timer_pend, ext_q;
    logic [CNT_W-1:0] count_q, count_inc, compare_q;
    logic [DATA_W-1:0] cause_w;

    assign cnt_wr = wr_en && (wr_addr == A_COUNT);
    assign cmp_wr = wr_en && (wr_addr == A_COMPARE);

    tmr_counter #(.CNT_W(CNT_W), .RST_VAL(CNT_W'(1))) cnt_i (
        .clk(clk), .rst(rst), .tick(tick_en), .load(cnt_wr),
        .load_val(wr_data[CNT_W-1:0]), .count_q(count_q), .count_inc(count_inc)
    );

    tmr_compare #(.CNT_W(CNT_W)) cmp_i (
        .clk(clk), .rst(rst), .load(cmp_wr), .load_val(wr_data[CNT_W-1:0]),
        .tick(tick_en), .count_load(cnt_wr), .count_inc(count_inc),
        .compare_q(compare_q), .hit(hit)
    );

    tmr_pend_fsm pend_i (
        .clk(clk), .rst(rst), .hit(hit), .clear(cmp_wr), .pending(timer_pend)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ext_q <= 1'b0;
        else
            ext_q <= ext_irq;
    end

    always_comb begin
        cause_w          = '0;
        cause_w[TMR_BIT] = timer_pend;
        cause_w[EXT_BIT] = ext_q;
    end

    assign irq_out = timer_pend || ext_q;

    always_comb begin
        unique case (rd_addr)
            A_COUNT:   rd_data = DATA_W'(count_q);
            A_COMPARE: rd_data = DATA_W'(compare_q);
            A_CAUSE:   rd_data = cause_w;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cmp_tick_timer_chk.sv
module cmp_tick_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic             ext_irq,
    input logic             irq_out,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] compare_q,
    input logic             timer_pend
);
    logic cw, pw;
    assign cw = wr_en && (wr_addr == 2'd0);
    assign pw = wr_en && (wr_addr == 2'd1);

    assert_reset_vals_R1: assert property (@(posedge clk)
        rst |=> (count_q == CNT_W'(1) && compare_q == '0 && !timer_pend));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !cw) |=> count_q == CNT_W'($past(count_q) + CNT_W'(1)));

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !cw) |=> $stable(count_q));

    assert_compare_kept_R3: assert property (@(posedge clk) disable iff (rst)
        !pw |=> $stable(compare_q));

    assert_match_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !cw && !pw && (CNT_W'(count_q + CNT_W'(1)) == compare_q))
        |=> timer_pend);

    assert_cmp_clears_R5: assert property (@(posedge clk) disable iff (rst)
        pw |=> !timer_pend);

    assert_pend_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (timer_pend && !pw) |=> timer_pend);

    assert_ext_follow_R7: assert property (@(posedge clk) disable iff (rst)
        ext_irq |=> irq_out);

    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!ext_irq && !timer_pend && !(tick_en && !cw && !pw &&
         (CNT_W'(count_q + CNT_W'(1)) == compare_q))) |=> !irq_out);
endmodule

bind cmp_tick_timer cmp_tick_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .ext_irq(ext_irq), .irq_out(irq_out),
    .count_q(count_q), .compare_q(compare_q), .timer_pend(timer_pend)
);

// File: tb/cmp_tick_timer_tb_top.sv
`timescale 1ns/100ps
module cmp_tick_timer_tb_top;
    localparam int W = 8;
    localparam int MASK = (1 << W) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data;
    logic        ext_irq = 1'b0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cmp_tick_timer #(.CNT_W(W)) dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .ext_irq(ext_irq), .irq_out(irq_out)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = 32'(d);
        step();
        wr_en = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_rd(input string req, input logic [1:0] a, input int exp);
        rd_addr = a;
        #0.1;
        chk(req, rd_data, 32'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        // R1 reset state
        chk_rd("R1 count", 2'd0, 1);
        chk_rd("R1 compare", 2'd1, 0);
        chk_rd("R1 cause", 2'd2, 0);
        chk("R1 irq", 32'(irq_out), 0);

        // R2 counting and hold
        tick_en = 1'b1;
        repeat (5) step();
        chk_rd("R2 count after 5 ticks", 2'd0, 6);
        tick_en = 1'b0;
        repeat (3) step();
        chk_rd("R2 count held", 2'd0, 6);

        // R3 write priority and independence
        tick_en = 1'b1;
        wr(2'd0, 'h40);
        chk_rd("R3 count write beats tick", 2'd0, 'h40);
        chk_rd("R3 compare kept", 2'd1, 0);
        step();
        chk_rd("R3 count runs", 2'd0, 'h41);
        wr(2'd1, 'h80);
        chk_rd("R3 count runs on compare write", 2'd0, 'h42);
        chk_rd("R3 compare loaded", 2'd1, 'h80);
        tick_en = 1'b0;

        // R2 wrap
        wr(2'd1, 'h10);
        wr(2'd0, 'h1FF);
        chk_rd("R9 count zero-extended", 2'd0, 'hFF);
        tick_en = 1'b1; step(); tick_en = 1'b0;
        chk_rd("R2 wrap to zero", 2'd0, 0);
        chk_rd("R2 wrap no cause", 2'd2, 0);

        // R4/R5 sweep over every start value
        for (int c = 0; c <= MASK; c++) begin
            int d = (c % 4) + 1;
            tick_en = 1'b0;
            wr(2'd1, (c + d) & MASK);
            wr(2'd0, c);
            tick_en = 1'b1;
            repeat (d - 1) step();
            chk_rd("R4 no early match", 2'd2, 0);
            step();
            tick_en = 1'b0;
            chk_rd("R4 match sets bit 15", 2'd2, 'h8000);
            chk("R4 irq on match", 32'(irq_out), 1);
            if (c == 0) begin
                tick_en = 1'b1; repeat (7) step(); tick_en = 1'b0;
                chk_rd("R5 pending sticky", 2'd2, 'h8000);
            end
            wr(2'd1, c);
            chk_rd("R5 compare write clears", 2'd2, 0);
            chk("R5 irq drops", 32'(irq_out), 0);
        end

        // R5 compare write in the match cycle
        wr(2'd0, 'h20);
        wr(2'd1, 'h21);
        tick_en = 1'b1;
        wr(2'd1, 'h50);
        tick_en = 1'b0;
        chk_rd("R5 write beats match", 2'd2, 0);
        chk_rd("R5 count moved onto old compare", 2'd0, 'h21);

        // R6 equality via count write
        wr(2'd1, 'h33);
        wr(2'd0, 'h33);
        chk_rd("R6 no match at write", 2'd2, 0);
        tick_en = 1'b1;
        repeat (MASK) step();
        chk_rd("R6 no match before wrap", 2'd2, 0);
        chk_rd("R6 count before wrap", 2'd0, 'h32);
        step();
        tick_en = 1'b0;
        chk_rd("R6 match after full wrap", 2'd2, 'h8000);

        // R6 equality via compare write
        wr(2'd0, 'h77);
        wr(2'd1, 'h77);
        chk_rd("R6 compare-write equality no match", 2'd2, 0);
        tick_en = 1'b1;
        repeat (MASK) step();
        chk_rd("R6 compare path before wrap", 2'd2, 0);
        step();
        tick_en = 1'b0;
        chk_rd("R6 compare path match", 2'd2, 'h8000);
        chk_rd("R6 count back at start", 2'd0, 'h77);
        wr(2'd1, 'h00);

        // R7 external line
        ext_irq = 1'b1;
        chk_rd("R7 not yet sampled", 2'd2, 0);
        step();
        chk_rd("R7 bit 10 set", 2'd2, 'h400);
        chk("R8 irq from ext", 32'(irq_out), 1);
        ext_irq = 1'b0;
        step();
        chk_rd("R7 bit 10 clear", 2'd2, 0);
        chk("R8 irq low", 32'(irq_out), 0);

        // R8 both sources
        wr(2'd0, 'h05);
        wr(2'd1, 'h06);
        ext_irq = 1'b1;
        tick_en = 1'b1; step(); tick_en = 1'b0;
        chk_rd("R8 both bits", 2'd2, 'h8400);
        ext_irq = 1'b0;
        step();
        chk("R8 timer alone holds irq", 32'(irq_out), 1);
        wr(2'd1, 'h00);
        chk("R8 irq off when both clear", 32'(irq_out), 0);

        // R9 ignored writes
        wr(2'd0, 'h12);
        wr(2'd1, 'h34);
        wr(2'd2, 'hFFFF_FFFF);
        chk_rd("R9 cause unwritable", 2'd2, 0);
        wr(2'd3, 'hFFFF_FFFF);
        chk_rd("R9 count untouched", 2'd0, 'h12);
        chk_rd("R9 compare untouched", 2'd1, 'h34);
        chk_rd("R9 address 3 reads zero", 2'd3, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule